// File: doc/BRIEF.md
# Top-64 KB Chip-Enable Decoder

This block turns a 20-bit processor address into chip enables for eight 8 KB read-only devices. Together the devices fill the last 64 KB of a 1 MB memory map, from F0000H to FFFFFH. The block is purely combinational, so its outputs follow the inputs within the same cycle.

The top four address bits must all be ones, and the cycle must be a memory cycle, before any enable is driven. When both hold, address bits 15 to 13 pick which of the eight active-low chip enables goes low. Address bits 12 to 0 go straight to the devices and take no part in decoding.

The processor's active-low read strobe drives one output-enable line that all the devices share. That line is gated so that it goes low only while some device is selected. No data flows through the block, so there is no valid/ready interface and every pin is a plain control signal.

Top module: `csd_eprom_select`

## Requirements
- R1: At most one bit of `ce_n` is 0 at any time.
- R2: When `io_sel` is 0 and `mem_addr[19:16]` is 4'hF, bit `mem_addr[15:13]` of `ce_n` is 0 and all other bits are 1. For example, bit 0 covers F0000H–F1FFFH and bit 7 covers FE000H–FFFFFH.
- R3: When `mem_addr[19:16]` is not 4'hF, meaning any address below F0000H, `ce_n` is 8'hFF.
- R4: When `io_sel` is 1, which marks an IO cycle, `ce_n` is 8'hFF whatever the address.
- R5: Changing `mem_addr[12:0]` alone changes neither `ce_n` nor `oe_n`.
- R6: `oe_n` is 0 exactly when `rd_n` is 0 and some bit of `ce_n` is 0; otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mem_addr | input | 20 | Processor address; bits 19:13 are decoded, bits 12:0 are ignored |
| rd_n | input | 1 | Active-low read strobe from the processor |
| io_sel | input | 1 | 1 marks an IO cycle, 0 marks a memory cycle |
| ce_n | output | 8 | Active-low chip enable for each 8 KB device |
| oe_n | output | 1 | Active-low output enable shared by all devices |

## Verification
The checks assume that every input is at a defined 0 or 1 when they are sampled. They also assume the inputs change only once per bench cycle, so the combinational outputs have settled before they are examined. The stimulus meets these conditions by changing inputs on one clock edge and comparing outputs on the opposite edge. It walks every 2 KB step of the 1 MB space under all four combinations of read and IO/memory. It then varies the low offset bits inside every selected block to show they have no effect.

// File: rtl/csd_pkg.sv
package csd_pkg;
  parameter int unsigned ADDR_W    = 20;
  parameter int unsigned DEV_SEL_W = 3;
  parameter int unsigned OFFS_W    = 13;
  localparam int unsigned TAG_W    = ADDR_W - DEV_SEL_W - OFFS_W;
  localparam int unsigned NUM_DEV  = 1 << DEV_SEL_W;
endpackage

// File: rtl/csd_region_match.sv
module csd_region_match #(
  parameter int unsigned TAG_W = 4
) (
  input  logic [TAG_W-1:0] tag,
  input  logic             io_sel,
  output logic             hit
);
  always_comb begin
    hit = (tag == {TAG_W{1'b1}}) && !io_sel;
  end
endmodule

// File: rtl/csd_onehot_dec.sv
module csd_onehot_dec #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned N    = 1 << SEL_W
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [N-1:0]     out_n
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign out_n[i] = ~(en && (sel == SEL_W'(i)));
  end
endmodule

// File: rtl/csd_oe_gate.sv
module csd_oe_gate #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] ce_n,
  input  logic         rd_n,
  output logic         oe_n
);
  always_comb begin
    oe_n = ~(~rd_n && ~(&ce_n));
  end
endmodule

// File: rtl/csd_eprom_select.sv
module csd_eprom_select
  import csd_pkg::*;
#(
  parameter int unsigned P_ADDR_W    = ADDR_W,
  parameter int unsigned P_DEV_SEL_W = DEV_SEL_W,
  parameter int unsigned P_OFFS_W    = OFFS_W,
  localparam int unsigned L_TAG_W    = P_ADDR_W - P_DEV_SEL_W - P_OFFS_W,
  localparam int unsigned L_NUM_DEV  = 1 << P_DEV_SEL_W
) (
  input  logic [P_ADDR_W-1:0]  mem_addr,
  input  logic                 rd_n,
  input  logic                 io_sel,
  output logic [L_NUM_DEV-1:0] ce_n,
  output logic                 oe_n
);
  logic                   region_hit;
  logic [L_TAG_W-1:0]     addr_tag;
  logic [P_DEV_SEL_W-1:0] dev_sel;
  logic                   unused_offs;

  assign addr_tag    = mem_addr[P_ADDR_W-1 -: L_TAG_W];
  assign dev_sel     = mem_addr[P_OFFS_W +: P_DEV_SEL_W];
  assign unused_offs = ^mem_addr[P_OFFS_W-1:0];

  csd_region_match #(.TAG_W(L_TAG_W)) u_match (
    .tag    (addr_tag),
    .io_sel (io_sel),
    .hit    (region_hit)
  );

  csd_onehot_dec #(.SEL_W(P_DEV_SEL_W)) u_dec (
    .en    (region_hit),
    .sel   (dev_sel),
    .out_n (ce_n)
  );

  csd_oe_gate #(.N(L_NUM_DEV)) u_oe (
    .ce_n (ce_n),
    .rd_n (rd_n),
    .oe_n (oe_n)
  );
endmodule

// File: rtl/csd_eprom_select_chk.sv
module csd_eprom_select_chk (
  input logic [19:0] mem_addr,
  input logic        rd_n,
  input logic        io_sel,
  input logic [7:0]  ce_n,
  input logic        oe_n
);
  logic unused_low;
  assign unused_low = ^mem_addr[12:0];

  always_comb begin
    // R1
    a_r1_one_enable_max: assert ($onehot0(~ce_n));
    // R2
    if (!io_sel && mem_addr[19:16] == 4'hF)
      a_r2_selected_low: assert (ce_n[mem_addr[15:13]] == 1'b0 && $countones(~ce_n) == 1);
    // R3
    if (mem_addr[19:16] != 4'hF)
      a_r3_outside_idle: assert (ce_n == 8'hFF);
    // R4
    if (io_sel)
      a_r4_io_idle: assert (ce_n == 8'hFF);
    // R6
    if (!oe_n)
      a_r6_oe_needs_read: assert (!rd_n && ce_n != 8'hFF);
    if (!rd_n && ce_n != 8'hFF)
      a_r6_oe_follows_read: assert (!oe_n);
  end
endmodule

bind csd_eprom_select csd_eprom_select_chk u_chk (
  .mem_addr (mem_addr),
  .rd_n     (rd_n),
  .io_sel   (io_sel),
  .ce_n     (ce_n),
  .oe_n     (oe_n)
);

// File: tb/csd_eprom_select_bench.sv
module csd_eprom_select_bench;
  logic        clk = 1'b0;
  logic [19:0] mem_addr = 20'h0;
  logic        rd_n = 1'b1;
  logic        io_sel = 1'b1;
  logic [7:0]  ce_n;
  logic        oe_n;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  csd_eprom_select u_csd_eprom_select (
    .mem_addr (mem_addr),
    .rd_n     (rd_n),
    .io_sel   (io_sel),
    .ce_n     (ce_n),
    .oe_n     (oe_n)
  );

  function automatic logic [7:0] ref_ce(int a, bit io);
    if (io || a < 'hF0000) return 8'hFF;
    return ~(8'b1 << ((a >> 13) & 7));
  endfunction

  function automatic logic ref_oe(logic [7:0] ce, bit rd);
    return !(!rd && ce != 8'hFF);
  endfunction

  function automatic string tag_for(int a, bit io);
    if (io) return "R4";
    if (a < 'hF0000) return "R3";
    return "R2";
  endfunction

  task automatic apply(int a, bit rd, bit io);
    @(posedge clk);
    mem_addr = a[19:0];
    rd_n = rd;
    io_sel = io;
    @(negedge clk);
  endtask

  task automatic check_now(int a, bit rd, bit io);
    logic [7:0] e_ce;
    logic       e_oe;
    e_ce = ref_ce(a, io);
    e_oe = ref_oe(e_ce, rd);
    checks++;
    if (ce_n !== e_ce || $countones(~ce_n) > 1) begin
      fails++;
      $display("FAIL %s/R1 addr=%05h io=%0d ce_n=%02h expected %02h",
               tag_for(a, io), a, io, ce_n, e_ce);
    end
    checks++;
    if (oe_n !== e_oe) begin
      fails++;
      $display("FAIL R6 addr=%05h rd=%0d io=%0d oe_n=%0b expected %0b",
               a, rd, io, oe_n, e_oe);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] base_ce;
    logic       base_oe;
    // Idle state: IO cycle, no read (R4)
    apply(0, 1'b1, 1'b1);
    check_now(0, 1'b1, 1'b1);
    // Sweep every 2 KB step under all strobe combinations (R1 R2 R3 R4 R6)
    for (int blk = 0; blk < 512; blk++) begin
      for (int io = 0; io < 2; io++) begin
        for (int rd = 0; rd < 2; rd++) begin
          int a;
          a = blk * 2048 + ((blk * 37 + io * 5 + rd) % 2048);
          apply(a, rd[0], io[0]);
          check_now(a, rd[0], io[0]);
        end
      end
    end
    // Edges of the decoded window (R2 R3)
    apply('hEFFFF, 1'b0, 1'b0); check_now('hEFFFF, 1'b0, 1'b0);
    apply('hF0000, 1'b0, 1'b0); check_now('hF0000, 1'b0, 1'b0);
    apply('hFFFFF, 1'b0, 1'b0); check_now('hFFFFF, 1'b0, 1'b0);
    // R5: offset bits do not change outputs
    for (int dev = 0; dev < 8; dev++) begin
      int b;
      b = 'hF0000 + dev * 'h2000;
      apply(b, 1'b0, 1'b0);
      base_ce = ce_n;
      base_oe = oe_n;
      for (int k = 0; k < 13; k++) begin
        apply(b + (1 << k), 1'b0, 1'b0);
        checks++;
        if (ce_n !== base_ce || oe_n !== base_oe) begin
          fails++;
          $display("FAIL R5 addr=%05h ce_n=%02h oe_n=%0b expected %02h %0b",
                   b + (1 << k), ce_n, oe_n, base_ce, base_oe);
        end
      end
      apply(b + 'h1FFF, 1'b0, 1'b0);
      check_now(b + 'h1FFF, 1'b0, 1'b0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule